// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block holds the interrupt-detection stage for a bank of GPIO pins. Each pin has its own detector. A detector takes the pin's already-debounced level and that pin's control bits. From them it produces three things: a sticky interrupt status bit, a sticky wake status bit and a masked interrupt request. A single OR of all pin requests gives the bank-level request line.

Every pin has these control bits:
- a sensitivity select: level or edge;
- a two-bit polarity code;
- a capture enable;
- a request unmask;
- a wake enable.

The enable and the unmask act at two different points. The enable decides whether a detected condition is recorded in status. The unmask decides only whether a recorded status reaches the request output. Software clears either status bit with a one-cycle write-one pulse on that bit's own clear input.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is low, every status bit and every request is 0. In the first clock after reset is released, no edge is detected, even if the pin is already at its active level.
- R2: In level mode (`lvl_mode`=1), polarity code 00 captures while the pin is low and code 01 captures while the pin is high. Status goes to 1 on the clock edge at which the condition is sampled.
- R3: In edge mode (`lvl_mode`=0), the current level is compared with the level sampled at the previous clock edge. Code 00 captures a high-to-low change, code 01 a low-to-high change and code 10 either change. Status then stays at 1 until it is cleared.
- R4: Polarity code 11 never captures, in either mode. Code 10 never captures in level mode.
- R5: With `irq_en`=0 nothing is captured. Status already captured stays unchanged while the pin is disabled.
- R6: `irq_req` for a pin is 1 only when its interrupt status is 1 and its `irq_unmask` bit is 1. The unmask bit has no effect on the status bits.
- R7: A 1 on `clr_int` clears that pin's interrupt status at the next edge. If a capture happens in the same cycle, the capture wins. In level mode the status therefore stays set while the active level persists.
- R8: Wake status is set by a capture while `wake_en`=1. It is cleared only by its own `clr_wake`, independently of interrupt status.
- R9: `irq_any` is 1 exactly when at least one pin's `irq_req` is 1.
- R10: Pins are independent. Stimulus and control on one pin never change another pin's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | N_PINS | Debounced pin levels |
| lvl_mode | input | N_PINS | 1 = level sensitive, 0 = edge sensitive |
| sense_sel | input | N_PINS x 2 | Polarity code per pin: 00 low/falling, 01 high/rising, 10 both edges, 11 reserved |
| irq_en | input | N_PINS | Capture enable per pin |
| irq_unmask | input | N_PINS | 1 lets captured status drive the request |
| wake_en | input | N_PINS | 1 lets a capture also set wake status |
| clr_int | input | N_PINS | Write-one clear of interrupt status |
| clr_wake | input | N_PINS | Write-one clear of wake status |
| int_sts | output | N_PINS | Sticky interrupt status |
| wake_sts | output | N_PINS | Sticky wake status |
| irq_req | output | N_PINS | Masked per-pin request |
| irq_any | output | 1 | OR of all per-pin requests |

## Verification
The main sweep runs on every pin. It covers all combinations of sensitivity, polarity code, enable, unmask, wake enable, and the previous and current pin level, and checks the outcome against a model computed in the bench.

- The transitions 0→1, 1→0 and steady levels separate rising, falling and both-edge capture from level capture.
- The reserved code shows up as the only code that never fires.
- The same sweep confirms that the pins left idle stay clear.

Directed sequences then cover the remaining behaviour:
- the first cycle after reset, which separates a real edge from the reset value of the history register;
- a clear issued while a level condition persists, which shows that the capture wins over the clear;
- toggling the unmask bit on captured status, which separates gating of the request from gating of the status.

// File: rtl/gpio_irqdet_pkg.sv
// Package: shared encodings for the GPIO interrupt detector.
// Assumes: the polarity code is two bits wide and decoded identically on every pin.
package gpio_irqdet_pkg;

    // Polarity / edge selection code carried in sense_sel.
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,  // active low level, or falling edge
        SENSE_HIGH = 2'b01,  // active high level, or rising edge
        SENSE_BOTH = 2'b10,  // either edge (edge mode only)
        SENSE_RSVD = 2'b11   // reserved, never detects
    } sense_e;

endpackage

// File: rtl/gpio_irqdet_sense.sv
// Module: gpio_irqdet_sense
// Decides, for one pin, whether the current cycle carries a qualifying
// interrupt condition. It keeps the previous-cycle pin level for edge
// detection, plus a primed flag, so the reset value of that history cannot
// fake an edge.
// Assumes: pin_lvl is already synchronous and debounced.
module gpio_irqdet_sense
    import gpio_irqdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_lvl,
    input  logic       lvl_mode,
    input  logic [1:0] sense_sel,
    input  logic       irq_en,
    output logic       hit
);

    logic prev_lvl;
    logic primed;
    logic rise;
    logic fall;
    logic level_hit;
    logic edge_hit;

    // Record the last sampled level; primed goes high after the first post-reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= 1'b0;
            primed   <= 1'b0;
        end else begin
            prev_lvl <= pin_lvl;
            primed   <= 1'b1;
        end
    end

    // Edge qualifiers, valid only once a real previous sample exists.
    always_comb begin
        rise = primed & ~prev_lvl &  pin_lvl;
        fall = primed &  prev_lvl & ~pin_lvl;
    end

    // Decode the polarity code for both sensitivities.
    always_comb begin
        level_hit = 1'b0;
        edge_hit  = 1'b0;
        case (sense_e'(sense_sel))
            SENSE_LOW: begin
                level_hit = ~pin_lvl;
                edge_hit  = fall;
            end
            SENSE_HIGH: begin
                level_hit = pin_lvl;
                edge_hit  = rise;
            end
            SENSE_BOTH: begin
                level_hit = 1'b0;
                edge_hit  = rise | fall;
            end
            default: begin
                level_hit = 1'b0;
                edge_hit  = 1'b0;
            end
        endcase
    end

    // Pick the sensitivity and apply the capture enable.
    always_comb begin
        hit = irq_en & (lvl_mode ? level_hit : edge_hit);
    end

endmodule

// File: rtl/gpio_irqdet_w1c.sv
// Module: gpio_irqdet_w1c
// A vector of sticky status bits with write-one-to-clear.
// A set and a clear of the same bit in the same cycle leave the bit set.
// Assumes: set and clr are single-cycle strobes that are synchronous to clk.
module gpio_irqdet_w1c #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] q
);

    // Per-bit sticky update: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= set | (q & ~clr);
        end
    end

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect (top)
// Interrupt detection for N_PINS GPIO pins.
// Each pin has a condition detector, a sticky interrupt status bit and a
// sticky wake status bit. Its request is the interrupt status gated by the
// pin's unmask bit. All requests are ORed into irq_any.
// Assumes: control inputs are quasi-static register outputs and clears are
// one-cycle pulses.
module gpio_irq_detect
    import gpio_irqdet_pkg::*;
#(
    parameter int N_PINS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PINS-1:0]      pin_lvl,
    input  logic [N_PINS-1:0]      lvl_mode,
    input  logic [N_PINS-1:0][1:0] sense_sel,
    input  logic [N_PINS-1:0]      irq_en,
    input  logic [N_PINS-1:0]      irq_unmask,
    input  logic [N_PINS-1:0]      wake_en,
    input  logic [N_PINS-1:0]      clr_int,
    input  logic [N_PINS-1:0]      clr_wake,
    output logic [N_PINS-1:0]      int_sts,
    output logic [N_PINS-1:0]      wake_sts,
    output logic [N_PINS-1:0]      irq_req,
    output logic                   irq_any
);

    logic [N_PINS-1:0] hit;
    logic [N_PINS-1:0] wake_set;

    // One condition detector per pin.
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        gpio_irqdet_sense u_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_lvl   (pin_lvl[g]),
            .lvl_mode  (lvl_mode[g]),
            .sense_sel (sense_sel[g]),
            .irq_en    (irq_en[g]),
            .hit       (hit[g])
        );
    end

    // Wake capture follows the interrupt capture, gated by the wake enable.
    always_comb begin
        wake_set = hit & wake_en;
    end

    gpio_irqdet_w1c #(.WIDTH(N_PINS)) u_int_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit),
        .clr   (clr_int),
        .q     (int_sts)
    );

    gpio_irqdet_w1c #(.WIDTH(N_PINS)) u_wake_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wake_set),
        .clr   (clr_wake),
        .q     (wake_sts)
    );

    // Mask stage: only captured and unmasked status raises a request.
    always_comb begin
        irq_req = int_sts & irq_unmask;
        irq_any = |irq_req;
    end

endmodule

// File: rtl/gpio_irqdet_chk.sv
// Module: gpio_irqdet_chk
// Temporal checks on gpio_irq_detect, attached through bind.
module gpio_irqdet_chk #(
    parameter int N_PINS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_PINS-1:0]      pin_lvl,
    input logic [N_PINS-1:0]      lvl_mode,
    input logic [N_PINS-1:0][1:0] sense_sel,
    input logic [N_PINS-1:0]      irq_en,
    input logic [N_PINS-1:0]      irq_unmask,
    input logic [N_PINS-1:0]      clr_int,
    input logic [N_PINS-1:0]      int_sts,
    input logic [N_PINS-1:0]      wake_sts,
    input logic [N_PINS-1:0]      irq_req
);

    for (genvar g = 0; g < N_PINS; g++) begin : g_chk
        // R7
        sts_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(int_sts[g]) |-> $past(clr_int[g]));

        // R5
        sts_rise_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(int_sts[g]) |-> $past(irq_en[g]));

        // R4
        rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(int_sts[g]) |-> ($past(sense_sel[g]) != 2'b11));

        // R8
        wake_with_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(wake_sts[g]) |-> int_sts[g]);

        // R6
        masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_unmask[g] |-> !irq_req[g]);

        // R3
        fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(int_sts[g]) && !$past(lvl_mode[g]) && ($past(sense_sel[g]) == 2'b00))
            |-> ($past(pin_lvl[g], 2) && !$past(pin_lvl[g])));
    end

endmodule

bind gpio_irq_detect gpio_irqdet_chk #(.N_PINS(N_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_lvl    (pin_lvl),
    .lvl_mode   (lvl_mode),
    .sense_sel  (sense_sel),
    .irq_en     (irq_en),
    .irq_unmask (irq_unmask),
    .clr_int    (clr_int),
    .int_sts    (int_sts),
    .wake_sts   (wake_sts),
    .irq_req    (irq_req)
);

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;

    localparam int N = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N-1:0]      pin_lvl;
    logic [N-1:0]      lvl_mode;
    logic [N-1:0][1:0] sense_sel;
    logic [N-1:0]      irq_en;
    logic [N-1:0]      irq_unmask;
    logic [N-1:0]      wake_en;
    logic [N-1:0]      clr_int;
    logic [N-1:0]      clr_wake;
    logic [N-1:0]      int_sts;
    logic [N-1:0]      wake_sts;
    logic [N-1:0]      irq_req;
    logic              irq_any;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    gpio_irq_detect #(.N_PINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .lvl_mode(lvl_mode),
        .sense_sel(sense_sel), .irq_en(irq_en), .irq_unmask(irq_unmask),
        .wake_en(wake_en), .clr_int(clr_int), .clr_wake(clr_wake),
        .int_sts(int_sts), .wake_sts(wake_sts), .irq_req(irq_req),
        .irq_any(irq_any)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: leave the negedge, pass the posedge, return on the next negedge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Capture decision computed from the requirement text.
    function automatic bit exp_hit(bit lm, bit [1:0] code, bit en, bit a, bit b);
        if (!en) return 1'b0;
        if (lm) begin
            if (code == 2'b00) return !b;
            if (code == 2'b01) return b;
            return 1'b0;
        end
        if (code == 2'b00) return a & !b;
        if (code == 2'b01) return !a & b;
        if (code == 2'b10) return a ^ b;
        return 1'b0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Reset with pins already configured to fire.
        rst_n = 1'b0;
        pin_lvl = 4'b0011;
        lvl_mode = 4'b0010;
        sense_sel = '{default: 2'b01};
        irq_en = 4'b0011;
        irq_unmask = 4'b1111;
        wake_en = 4'b1111;
        clr_int = '0;
        clr_wake = '0;
        @(negedge clk);
        tick();
        tick();
        chk(int_sts, 0, "R1", "int_sts in reset");
        chk(wake_sts, 0, "R1", "wake_sts in reset");
        chk({irq_any, irq_req}, 0, "R1", "requests in reset");
        rst_n = 1'b1;
        lvl_mode = 4'b0000;
        tick();
        tick();
        tick();
        chk(int_sts[0], 0, "R1", "no edge from reset history");
        irq_en = '0;
        pin_lvl = '0;
        clr_int = '1;
        clr_wake = '1;
        tick();
        clr_int = '0;
        clr_wake = '0;
        tick();

        // Sweep: every pin, every control combination, every level pair.
        for (int p = 0; p < N; p++) begin
            for (int c = 0; c < 256; c++) begin
                bit lm, en, a, b, mk, wk, h;
                bit [1:0] code;
                lm = c[0]; code = c[2:1]; en = c[3]; a = c[4];
                b = c[5]; mk = c[6]; wk = c[7];
                h = exp_hit(lm, code, en, a, b);
                irq_en = '0;
                pin_lvl[p] = a;
                tick();
                tick();
                clr_int[p] = 1'b1;
                clr_wake[p] = 1'b1;
                tick();
                clr_int[p] = 1'b0;
                clr_wake[p] = 1'b0;
                lvl_mode[p] = lm;
                sense_sel[p] = code;
                irq_unmask[p] = mk;
                wake_en[p] = wk;
                irq_en[p] = en;
                pin_lvl[p] = b;
                tick();
                if (lm) chk(int_sts[p], h, (code == 2'b11 || code == 2'b10) ? "R4" : "R2", "level capture");
                else    chk(int_sts[p], h, (code == 2'b11) ? "R4" : "R3", "edge capture");
                chk(wake_sts[p], h & wk, "R8", "wake capture");
                chk(irq_req[p], h & mk, "R6", "masked request");
                chk(irq_any, h & mk, "R9", "any request");
                chk(int_sts & ~(4'b1 << p), 0, "R10", "other pins idle");
            end
            irq_en = '0;
            clr_int = '1;
            clr_wake = '1;
            tick();
            clr_int = '0;
            clr_wake = '0;
            pin_lvl = '0;
            tick();
        end
        chk(int_sts, 0, "R5", "disabled sweep leaves clear");

        // Level high on pin 1: a clear during the active level loses.
        lvl_mode[1] = 1'b1; sense_sel[1] = 2'b01; irq_unmask[1] = 1'b1;
        wake_en[1] = 1'b0; irq_en[1] = 1'b1; pin_lvl[1] = 1'b1;
        tick();
        chk(int_sts[1], 1, "R2", "level high captured");
        clr_int[1] = 1'b1;
        tick();
        chk(int_sts[1], 1, "R7", "set beats clear");
        clr_int[1] = 1'b0;
        pin_lvl[1] = 1'b0;
        tick();
        chk(int_sts[1], 1, "R7", "held after level gone");
        clr_int[1] = 1'b1;
        tick();
        clr_int[1] = 1'b0;
        chk(int_sts[1], 0, "R7", "cleared once level gone");
        irq_en[1] = 1'b0;

        // Rising edge on pin 2 with wake, then sticky hold.
        lvl_mode[2] = 1'b0; sense_sel[2] = 2'b01; irq_unmask[2] = 1'b1;
        wake_en[2] = 1'b1; irq_en[2] = 1'b1; pin_lvl[2] = 1'b0;
        tick();
        chk(int_sts[2], 0, "R3", "no edge on steady low");
        pin_lvl[2] = 1'b1;
        tick();
        chk({wake_sts[2], int_sts[2]}, 2'b11, "R3", "rise captured with wake");
        tick(); tick(); tick();
        pin_lvl[2] = 1'b0;
        tick();
        chk(int_sts[2], 1, "R3", "sticky after falling");
        clr_wake[2] = 1'b1;
        tick();
        clr_wake[2] = 1'b0;
        chk({wake_sts[2], int_sts[2]}, 2'b01, "R8", "wake cleared alone");
        irq_en[2] = 1'b0;
        pin_lvl[2] = 1'b1;
        tick(); tick();
        chk(int_sts[2], 1, "R5", "status kept while disabled");
        irq_unmask[2] = 1'b0;
        #1;
        chk({irq_any, irq_req[2], int_sts[2]}, 3'b001, "R6", "mask hides request only");
        irq_unmask[2] = 1'b1;
        #1;
        chk(irq_req[2], 1, "R6", "unmask restores request");

        // Pin 3 active low level: OR of two requests.
        lvl_mode[3] = 1'b1; sense_sel[3] = 2'b00; irq_unmask[3] = 1'b1;
        wake_en[3] = 1'b0; irq_en[3] = 1'b1; pin_lvl[3] = 1'b0;
        tick();
        chk(irq_req, 4'b1100, "R9", "two pins requesting");
        clr_int[2] = 1'b1;
        tick();
        clr_int[2] = 1'b0;
        chk({irq_any, irq_req}, 5'b11000, "R9", "any from remaining pin");
        irq_en[3] = 1'b0;
        clr_int[3] = 1'b1;
        tick();
        clr_int[3] = 1'b0;
        chk({irq_any, int_sts}, 5'b00000, "R9", "all quiet");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule